// File: doc/BRIEF.md
# Synchronizable Center-Aligned PWM Channel

This block is one PWM channel with a triangular time base. A counter rises from zero to a programmed period and falls back to zero. One full triangle therefore lasts twice the period value in clock ticks. A compare value is checked against the counter. A match while the triangle is rising drives the output low, and a match while it is falling drives it high. The high pulse is centred on the bottom of the triangle, and its width is twice the compare value. Both the period and the compare value are written into shadow copies first, and those copies reach the counter logic only at fixed points of the triangle.

Several channels can be chained so that three phases share one time base. Each channel has a sync input and a sync output. An incoming pulse is held in a flip-flop for one clock. If phase loading is enabled, the registered pulse then forces the counter to a programmed phase value and sets the counting direction. The sync output is selectable:

- it can flag the counter's zero point, so the channel acts as a master, or
- it can forward the registered sync input, so the channel passes the pulse along a chain.

Each stage of a chain adds exactly one clock of latency.

Top module: `pwm_sync_chan`

## Requirements
- R1: The counter steps by one per clock from 0 up to the active period and back down to 0, giving a triangle of twice the period in ticks. With an active period of 0 the counter holds at 0. The counter value is visible on `ctrOut`.
- R2: A write to address 0 sets the period shadow. The active period takes the shadow value only on a clock in which the counter is 0.
- R3: A write to address 1 sets the compare shadow. The active compare takes the shadow value on a clock in which the counter is 0 and on a clock in which it equals the active period.
- R4: A compare match drives `pwmOut` in the next clock. The output goes low when the counter is heading up (at 0, or rising below the period) and high when it is heading down (at the period, or falling). For 0 < compare < period, the output is high for 2×compare ticks of every 2×period ticks.
- R5: Address 2 holds the phase value. Address 3 holds the mode: bit 0 enables phase loading, bit 1 selects the direction after a load (0 up, 1 down), and bit 2 selects the sync output. With bit 0 set, a registered sync pulse loads the counter with the phase value and direction. With bit 0 clear, the sync pulse has no effect on the counter.
- R6: With mode bit 2 clear, `syncOut` is high while the counter is 0. With mode bit 2 set, `syncOut` forwards the registered sync input.
- R7: `syncIn` is registered for one clock, so each pass-through stage delays the pulse by one clock. A phase load shows on `ctrOut` two clocks after the clock in which `syncIn` is high.
- R8: An active compare value of 0 keeps `pwmOut` low.
- R9: A compare value at or above the period produces no up-match. Above the period, the output holds its previous level. A slave loaded with phase 0 from a master's zero pulse trails the master by two counts. Channels that start together with phase loading disabled stay in step.
- R10: After reset the counter is 0 and heading up, `pwmOut` is low, and all shadow, active, phase and mode registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | AW | Register address (0 period, 1 compare, 2 phase, 3 mode) |
| wrData | input | CW | Register write data |
| syncIn | input | 1 | Sync pulse from the upstream channel |
| syncOut | output | 1 | Sync pulse to the downstream channel |
| pwmOut | output | 1 | PWM output |
| ctrOut | output | CW | Current time-base count |

## Verification
The hardest case to reach is a phase load that lands while the active period is smaller than the loaded phase value, or in the same clock as a shadow transfer at zero or at the peak. In that case the counter must fold back from above the period, and the compare and period copies must update on the right clock. Three channels are chained in the bench. Random register writes with small periods, together with random external sync pulses, drive the master and the two slaves into these collisions. Each channel is compared clock by clock against a bench model built from the requirements.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

  // register addresses on the write bus
  localparam int ADDR_PRD  = 0;
  localparam int ADDR_CMP  = 1;
  localparam int ADDR_PHS  = 2;
  localparam int ADDR_MODE = 3;

  // mode register layout
  localparam int MODE_W        = 3;
  localparam int MODE_PHEN     = 0;
  localparam int MODE_PHDOWN   = 1;
  localparam int MODE_SYNCPASS = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseLoad;
    logic phaseDown;
  } tbStrobe_t;

endpackage

// File: rtl/pwm_sync_ctrl.sv
module pwm_sync_ctrl
  import pwm_sync_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [CW-1:0] wrData,
  input  logic          syncIn,
  input  logic          ctrAtZero,
  output logic [CW-1:0] prdShadow,
  output logic [CW-1:0] cmpShadow,
  output logic [CW-1:0] phaseVal,
  output tbStrobe_t     strb,
  output logic          syncOut
);

  logic [MODE_W-1:0] modeQ;
  logic              syncInQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      prdShadow <= '0;
      cmpShadow <= '0;
      phaseVal  <= '0;
      modeQ     <= '0;
      syncInQ   <= 1'b0;
    end else begin
      syncInQ <= syncIn;
      if (wrEn) begin
        case (wrAddr)
          AW'(ADDR_PRD):  prdShadow <= wrData;
          AW'(ADDR_CMP):  cmpShadow <= wrData;
          AW'(ADDR_PHS):  phaseVal  <= wrData;
          AW'(ADDR_MODE): modeQ     <= wrData[MODE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb.phaseLoad = modeQ[MODE_PHEN] & syncInQ;
    strb.phaseDown = modeQ[MODE_PHDOWN];
  end

  assign syncOut = modeQ[MODE_SYNCPASS] ? syncInQ : ctrAtZero;

  // R7
  sync_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (syncIn && modeQ[MODE_PHEN] && !wrEn) |=> strb.phaseLoad);

endmodule

// File: rtl/pwm_sync_dp.sv
module pwm_sync_dp
  import pwm_sync_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] prdShadow,
  input  logic [CW-1:0] cmpShadow,
  input  logic [CW-1:0] phaseVal,
  input  tbStrobe_t     strb,
  output logic [CW-1:0] ctr,
  output logic          ctrAtZero,
  output logic          pwmOut
);

  logic [CW-1:0] cnt, cntNxt, prdAct, cmpAct;
  logic          dirUp, dirUpNxt, pwmQ;
  logic          atZero, atPeak, headingUp, cmpHit;

  assign atZero    = (cnt == '0);
  assign atPeak    = (cnt == prdAct);
  assign headingUp = (prdAct == '0) | (dirUp ? (cnt < prdAct) : atZero);
  assign cmpHit    = (cnt == cmpAct);

  always_comb begin
    cntNxt   = cnt;
    dirUpNxt = dirUp;
    if (strb.phaseLoad) begin
      cntNxt   = phaseVal;
      dirUpNxt = ~strb.phaseDown;
    end else if (prdAct == '0) begin
      cntNxt   = '0;
      dirUpNxt = 1'b1;
    end else if (dirUp) begin
      if (cnt >= prdAct) begin
        dirUpNxt = 1'b0;
        cntNxt   = cnt - CW'(1);
      end else begin
        cntNxt = cnt + CW'(1);
      end
    end else begin
      if (atZero) begin
        dirUpNxt = 1'b1;
        cntNxt   = cnt + CW'(1);
      end else begin
        cntNxt = cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dirUp  <= 1'b1;
      prdAct <= '0;
      cmpAct <= '0;
      pwmQ   <= 1'b0;
    end else begin
      cnt   <= cntNxt;
      dirUp <= dirUpNxt;
      if (atZero) prdAct <= prdShadow;
      if (atZero || atPeak) cmpAct <= cmpShadow;
      if (cmpHit) pwmQ <= ~headingUp;
    end
  end

  assign ctr       = cnt;
  assign ctrAtZero = atZero;
  assign pwmOut    = pwmQ;

  // R1
  ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.phaseLoad && prdAct != '0) |=>
      ((cnt == ($past(cnt) + CW'(1))) || (cnt == ($past(cnt) - CW'(1)))));

  // R2
  prd_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(prdAct) |-> ($past(cnt) == '0));

  // R3
  cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmpAct) |-> (($past(cnt) == '0) || ($past(cnt) == $past(prdAct))));

  // R9
  pwm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != cmpAct) |=> $stable(pwmOut));

  // R8
  zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (cmpAct == '0 && !pwmQ) |=> !pwmQ);

endmodule

// File: rtl/pwm_sync_chan.sv
module pwm_sync_chan
  import pwm_sync_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [CW-1:0] wrData,
  input  logic          syncIn,
  output logic          syncOut,
  output logic          pwmOut,
  output logic [CW-1:0] ctrOut
);

  logic [CW-1:0] prdShadow, cmpShadow, phaseVal;
  logic          ctrAtZero;
  tbStrobe_t     strb;

  pwm_sync_ctrl #(.CW(CW), .AW(AW)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .syncIn    (syncIn),
    .ctrAtZero (ctrAtZero),
    .prdShadow (prdShadow),
    .cmpShadow (cmpShadow),
    .phaseVal  (phaseVal),
    .strb      (strb),
    .syncOut   (syncOut)
  );

  pwm_sync_dp #(.CW(CW)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .prdShadow (prdShadow),
    .cmpShadow (cmpShadow),
    .phaseVal  (phaseVal),
    .strb      (strb),
    .ctr       (ctrOut),
    .ctrAtZero (ctrAtZero),
    .pwmOut    (pwmOut)
  );

endmodule

// File: tb/pwm_sync_chan_tb.sv
module pwm_sync_chan_tb_top;

  localparam int CLK_P = 10;
  localparam int CW    = 16;
  localparam int NCH   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic [NCH-1:0] wrEnV  = '0;
  logic [1:0]     wrAddr = '0;
  logic [CW-1:0]  wrData = '0;
  logic           extSync = 1'b0;
  logic [NCH-1:0] pwmV, syncV;
  logic [CW-1:0]  ctr0, ctr1, ctr2;

  pwm_sync_chan #(.CW(CW)) dut_i (.clk(clk), .rst(rst), .wrEn(wrEnV[0]), .wrAddr(wrAddr),
    .wrData(wrData), .syncIn(extSync), .syncOut(syncV[0]), .pwmOut(pwmV[0]), .ctrOut(ctr0));
  pwm_sync_chan #(.CW(CW)) dut_b (.clk(clk), .rst(rst), .wrEn(wrEnV[1]), .wrAddr(wrAddr),
    .wrData(wrData), .syncIn(syncV[0]), .syncOut(syncV[1]), .pwmOut(pwmV[1]), .ctrOut(ctr1));
  pwm_sync_chan #(.CW(CW)) dut_c (.clk(clk), .rst(rst), .wrEn(wrEnV[2]), .wrAddr(wrAddr),
    .wrData(wrData), .syncIn(syncV[1]), .syncOut(syncV[2]), .pwmOut(pwmV[2]), .ctrOut(ctr2));

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ctrOf(int k);
    return (k == 0) ? int'(ctr0) : (k == 1) ? int'(ctr1) : int'(ctr2);
  endfunction

  // reference model, built from the requirements
  int mCnt[NCH], mPrdS[NCH], mPrd[NCH], mCmpS[NCH], mCmp[NCH], mPha[NCH], mMode[NCH];
  bit mUp[NCH], mSyncQ[NCH], mPwm[NCH];

  function automatic bit mSyncOut(int k);
    return mMode[k][2] ? mSyncQ[k] : (mCnt[k] == 0);
  endfunction

  always @(posedge clk) begin : model
    bit so[NCH];
    bit sIn, hUp;
    int oldPrd;
    for (int k = 0; k < NCH; k++) so[k] = mSyncOut(k);
    for (int k = 0; k < NCH; k++) begin
      if (rst) begin
        mCnt[k] = 0; mPrdS[k] = 0; mPrd[k] = 0; mCmpS[k] = 0; mCmp[k] = 0;
        mPha[k] = 0; mMode[k] = 0; mUp[k] = 1; mSyncQ[k] = 0; mPwm[k] = 0;
      end else begin
        sIn = (k == 0) ? extSync : so[k-1];
        oldPrd = mPrd[k];
        hUp = (oldPrd == 0) || (mUp[k] ? (mCnt[k] < oldPrd) : (mCnt[k] == 0));
        if (mCnt[k] == mCmp[k]) mPwm[k] = !hUp;
        if (mCnt[k] == 0 || mCnt[k] == oldPrd) mCmp[k] = mCmpS[k];
        if (mCnt[k] == 0) mPrd[k] = mPrdS[k];
        if (mMode[k][0] && mSyncQ[k]) begin
          mCnt[k] = mPha[k]; mUp[k] = !mMode[k][1];
        end else if (oldPrd == 0) begin
          mCnt[k] = 0; mUp[k] = 1;
        end else if (mUp[k]) begin
          if (mCnt[k] >= oldPrd) begin mUp[k] = 0; mCnt[k]--; end
          else mCnt[k]++;
        end else begin
          if (mCnt[k] == 0) begin mUp[k] = 1; mCnt[k]++; end
          else mCnt[k]--;
        end
        mSyncQ[k] = sIn;
        if (wrEnV[k]) begin
          case (wrAddr)
            2'd0: mPrdS[k] = int'(wrData);
            2'd1: mCmpS[k] = int'(wrData);
            2'd2: mPha[k]  = int'(wrData);
            default: mMode[k] = int'(wrData) & 7;
          endcase
        end
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int k = 0; k < NCH; k++) begin
        chk(ctrOf(k) == mCnt[k], $sformatf("R1/R2 counter ch%0d", k), ctrOf(k), mCnt[k]);
        chk(pwmV[k] == mPwm[k], $sformatf("R4/R3 output ch%0d", k), pwmV[k], mPwm[k]);
        chk(syncV[k] == mSyncOut(k), $sformatf("R6/R7 syncOut ch%0d", k), syncV[k], mSyncOut(k));
      end
    end
  end

  task automatic wr(logic [NCH-1:0] chs, int a, int d);
    wrEnV = chs; wrAddr = 2'(a); wrData = CW'(d);
    @(negedge clk);
    wrEnV = '0;
  endtask

  task automatic countHigh(int ch, int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); h += int'(pwmV[ch]); end
  endtask

  task automatic maxCtr(int n, output int m);
    m = 0;
    repeat (n) begin @(negedge clk); if (int'(ctr0) > m) m = int'(ctr0); end
  endtask

  initial begin : watchdog
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : stim
    int h, m, seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ctr0 == 0 && ctr1 == 0 && ctr2 == 0, "R10 counters after reset", int'(ctr0), 0);
    chk(pwmV == '0, "R10 outputs low after reset", int'(pwmV), 0);
    rst = 1'b0;
    @(negedge clk);

    wr('1, 0, 10);
    wr('1, 1, 3);
    wr(3'b010, 3, 1);   // slave: phase load, zero-mode sync out
    wr(3'b100, 3, 4);   // third: pass-through, no phase load
    repeat (60) @(negedge clk);
    // R4 duty
    countHigh(0, 20, h);
    chk(h == 6, "R4 high ticks per period", h, 6);
    // R9 lag and R5 ignore
    while (ctr0 != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(ctr0 == 5, "R1 master count", int'(ctr0), 5);
    chk(ctr1 == 3, "R9 slave lag from zero sync (R5 load)", int'(ctr1), 3);
    chk(ctr2 == 5, "R5 sync ignored without phase enable (R9 aligned)", int'(ctr2), 5);
    chk(pwmV[2] == pwmV[0], "R9 aligned outputs", pwmV[2], pwmV[0]);

    // R2 period shadow
    while (ctr0 != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    wr('1, 0, 6);
    maxCtr(12, m);
    chk(m == 10, "R2 old period kept until zero", m, 10);
    while (ctr0 != 0) @(negedge clk);
    maxCtr(12, m);
    chk(m == 6, "R2 new period after zero", m, 6);

    // R8 zero compare
    wr('1, 1, 0);
    repeat (30) @(negedge clk);
    countHigh(0, 12, h);
    chk(h == 0, "R8 zero compare gives zero duty", h, 0);
    // R9 compare above period holds low
    wr('1, 1, 9);
    repeat (30) @(negedge clk);
    countHigh(0, 12, h);
    chk(h == 0, "R9 compare above period holds", h, 0);
    // R9 compare equal to period: set at peak, never cleared
    wr('1, 1, 6);
    repeat (30) @(negedge clk);
    countHigh(0, 12, h);
    chk(h == 12, "R9 compare at period no up-match", h, 12);

    // R7 per-stage latency in pass-through
    wr('1, 3, 4);
    repeat (3) @(negedge clk);
    extSync = 1'b1;
    @(negedge clk);
    extSync = 1'b0;
    chk(syncV[0] == 1 && syncV[1] == 0, "R7 stage one latency", int'(syncV), 1);
    @(negedge clk);
    chk(syncV[0] == 0 && syncV[1] == 1, "R7 stage two latency", int'(syncV), 2);
    @(negedge clk);
    chk(syncV[2] == 1, "R7 stage three latency (R6 pass)", syncV[2], 1);

    // R5 phase load timing, up then down
    wr(3'b010, 2, 7);
    wr(3'b010, 3, 5);
    repeat (3) @(negedge clk);
    extSync = 1'b1;
    @(negedge clk);
    extSync = 1'b0;
    repeat (2) @(negedge clk);
    chk(ctr1 == 7, "R5 R7 phase load two clocks after sync", int'(ctr1), 7);
    wr(3'b010, 2, 3);
    wr(3'b010, 3, 7);
    repeat (3) @(negedge clk);
    extSync = 1'b1;
    @(negedge clk);
    extSync = 1'b0;
    repeat (2) @(negedge clk);
    chk(ctr1 == 3, "R5 phase load value", int'(ctr1), 3);
    @(negedge clk);
    chk(ctr1 == 2, "R5 direction down after load", int'(ctr1), 2);

    // constrained random phase, checked by the model
    for (int i = 0; i < 3000; i++) begin
      extSync = ($urandom % 16) == 0;
      if (($urandom % 8) == 0) begin
        int a, d;
        a = $urandom % 4;
        case (a)
          0: d = $urandom % 21;
          1: d = $urandom % 23;
          2: d = $urandom % 26;
          default: d = $urandom % 8;
        endcase
        wr(3'($urandom % 7 + 1), a, d);
      end else begin
        @(negedge clk);
      end
    end
    extSync = 1'b0;
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule